// File: doc/BRIEF.md
# PCM Codec Frame-Sync Serial Port

This block is the digital side of a telephony codec's serial interface, clocked from a fast system clock. On the transmit side it measures the transmit frame sync to tell short-frame timing from long-frame timing. It then drives an 8-bit companded sample onto a serial output, sign bit first, together with an output-enable that models a tri-state buffer. The enable turns on and off at the points the chosen mode defines.

On the receive side, a rising receive frame sync starts a capture of eight bits on the following falling bit-clock edges. The assembled byte is presented with a one-cycle valid strobe. A flag marks frames whose receive sync lasted two bit clocks, meaning the least significant bit carried signalling and the decoder should treat it as a half step.

The bit clock, both frame syncs and the serial input all pass through two-stage synchronizers, and every decision is made on the synchronized edges. The transmit mode is held in a register that is updated each time the transmit sync falls. A frame whose sync width does not match the mode already held is dropped.

Top module: `pcm_frame_port`

## Requirements
- R1: After reset, dx_oe, rx_valid and mode_long are all 0.
- R2: When fsx falls, mode_long becomes 0 if fsx was high across exactly one rising bclk edge, and 1 if it was high across three or more. Other widths leave it unchanged.
- R3: In long mode (mode_long=1), dx_oe turns on at the first rising bclk edge while fsx is high, or at the fsx rise if bclk is already high. dx then carries bit 7 first, and each later rising edge advances one bit toward bit 0.
- R4: In short mode (mode_long=0), after a one-edge fsx pulse, dx_oe turns on at the first rising bclk edge after fsx falls, with bit 7 first and one bit per rising edge.
- R5: dx_oe turns off at whichever comes later: the falling bclk edge after the eighth rising edge of the frame, or fsx going low.
- R6: The tx_word value sampled at an fsx rise is the byte sent in the frame started by the next fsx rise.
- R7: A frame whose fsx width does not match the held mode sends no further bits. dx_oe is 0 from the fsx fall on. The width still updates the mode as in R2.
- R8: After an fsr rise, dr is sampled on the next eight falling bclk edges. The first sample lands in bit 7 of rx_word. rx_word is then updated together with a rx_valid pulse lasting one system clock.
- R9: rx_sig, updated with each rx_valid, is 1 exactly when fsr was high across two rising bclk edges.
- R10: dx changes only in response to a rising bclk edge or an fsx rise, so it holds steady through the low half of each bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than bclk |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Bit clock (asynchronous) |
| fsx | input | 1 | Transmit frame sync |
| fsr | input | 1 | Receive frame sync |
| dr | input | 1 | Serial receive data |
| tx_word | input | WORD_W | Byte to be sent in the following frame |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Output enable for dx |
| mode_long | output | 1 | 1 = long-frame mode held |
| rx_word | output | WORD_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_word |
| rx_sig | output | 1 | Receive sync was two bit clocks wide |

## Verification
The hardest state to reach is a mode mismatch. A frame can arrive with a width that contradicts the held mode, and in long mode the first bits are already on the wire before the short or two-edge width shows itself. The stimulus gets there by starting from reset (short mode) with a long pulse, then feeding long-mode frames of one and two edges, and then randomly mixing widths, so that abort frames follow and precede good ones. This also exercises the one-frame byte pipeline across dropped frames.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  // Saturating measure of how many rising bit-clock edges a sync pulse spanned
  typedef enum logic [1:0] {
    FSW_NONE = 2'd0,
    FSW_ONE  = 2'd1,
    FSW_TWO  = 2'd2,
    FSW_MANY = 2'd3
  } fs_width_e;

  function automatic fs_width_e width_step(fs_width_e w);
    logic [1:0] t;
    t = w + 2'd1;
    return (w == FSW_MANY) ? FSW_MANY : fs_width_e'(t);
  endfunction
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prev
);
  logic [W-1:0] st [STAGES+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i <= STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign lvl  = st[STAGES-1];
  assign prev = st[STAGES];
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
  import pcm_port_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_lvl,
  input  logic              bclk_rise,
  input  logic              bclk_fall,
  input  logic              fs_lvl,
  input  logic              fs_rise,
  input  logic              fs_fall,
  input  logic [WORD_W-1:0] word_i,
  output logic              dx_o,
  output logic              oe_o,
  output logic              long_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W);

  logic [WORD_W-1:0] hold_q, sh_q;
  logic [CNT_W-1:0]  bits_q;
  logic              active_q, fall8_q, armed_q, long_q, dx_q, oe_q;
  fs_width_e         wid_q;

  logic long_go, short_go, last, mismatch, release_now;

  assign long_go  = long_q && ((fs_rise && bclk_lvl) ||
                               (armed_q && fs_lvl && bclk_rise && !fs_rise));
  assign short_go = !long_q && armed_q && !fs_lvl && bclk_rise;
  assign last     = (bits_q == LAST);
  assign mismatch = fs_fall && (long_q ? (wid_q != FSW_MANY) : (wid_q != FSW_ONE));
  assign release_now = active_q && !fs_lvl && (fall8_q || (last && bclk_fall));

  // Pulse width measure and mode register
  always_ff @(posedge clk) begin
    if (rst) begin
      wid_q  <= FSW_NONE;
      long_q <= 1'b0;
    end else begin
      if (fs_rise)                 wid_q <= FSW_NONE;
      else if (fs_lvl && bclk_rise) wid_q <= width_step(wid_q);
      if (fs_fall) begin
        if (wid_q == FSW_ONE)       long_q <= 1'b0;
        else if (wid_q == FSW_MANY) long_q <= 1'b1;
      end
    end
  end

  // Frame sequencing and shifter
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      sh_q     <= '0;
      bits_q   <= '0;
      active_q <= 1'b0;
      fall8_q  <= 1'b0;
      armed_q  <= 1'b0;
      dx_q     <= 1'b0;
      oe_q     <= 1'b0;
    end else if (fs_rise) begin
      hold_q  <= word_i;
      armed_q <= !long_go;
      fall8_q <= 1'b0;
      if (long_go) begin
        oe_q     <= 1'b1;
        active_q <= 1'b1;
        dx_q     <= hold_q[WORD_W-1];
        sh_q     <= {hold_q[WORD_W-2:0], 1'b0};
        bits_q   <= CNT_W'(1);
      end else begin
        oe_q     <= 1'b0;
        active_q <= 1'b0;
        sh_q     <= hold_q;
        bits_q   <= '0;
      end
    end else if (long_go || short_go) begin
      oe_q     <= 1'b1;
      active_q <= 1'b1;
      armed_q  <= 1'b0;
      fall8_q  <= 1'b0;
      dx_q     <= sh_q[WORD_W-1];
      sh_q     <= {sh_q[WORD_W-2:0], 1'b0};
      bits_q   <= CNT_W'(1);
    end else if (mismatch) begin
      armed_q  <= 1'b0;
      active_q <= 1'b0;
      oe_q     <= 1'b0;
    end else if (release_now) begin
      active_q <= 1'b0;
      oe_q     <= 1'b0;
    end else if (active_q) begin
      if (bclk_rise && !last) begin
        dx_q   <= sh_q[WORD_W-1];
        sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
        bits_q <= bits_q + CNT_W'(1);
      end
      if (bclk_fall && last) fall8_q <= 1'b1;
    end
  end

  assign dx_o   = dx_q;
  assign oe_o   = oe_q;
  assign long_o = long_q;

  // R10: serial data moves only on a bit-clock rise or a frame-sync rise
  p_dx_steady_r10: assert property (@(posedge clk) disable iff (rst)
    (!bclk_rise && !fs_rise) |=> $stable(dx_q));
  // R5: outside a restart, the enable drops only with the sync low
  p_off_sync_low_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(oe_q) && !$past(fs_rise)) |-> !$past(fs_lvl));
  // R3 / R4: enable starts only on a bit-clock rise or a sync rise
  p_on_at_edge_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> $past(bclk_rise || fs_rise));
  // R3: never more bits than a word
  p_bits_bound_r3: assert property (@(posedge clk) disable iff (rst)
    bits_q <= LAST);
  // R2: mode moves only at a falling sync
  p_mode_at_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !fs_fall |=> $stable(long_q));
endmodule

// File: rtl/pcm_rx_port.sv
module pcm_rx_port
  import pcm_port_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_rise,
  input  logic              bclk_fall,
  input  logic              fs_lvl,
  input  logic              fs_rise,
  input  logic              dr_lvl,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              sig_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FINAL = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q, word_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, valid_q, sig_q;
  fs_width_e         wid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      word_q  <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      sig_q   <= 1'b0;
      wid_q   <= FSW_NONE;
    end else begin
      valid_q <= 1'b0;
      if (fs_rise)                  wid_q <= FSW_NONE;
      else if (fs_lvl && bclk_rise) wid_q <= width_step(wid_q);
      if (fs_rise) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q && bclk_fall) begin
        sh_q <= {sh_q[WORD_W-2:0], dr_lvl};
        if (cnt_q == FINAL) begin
          busy_q  <= 1'b0;
          word_q  <= {sh_q[WORD_W-2:0], dr_lvl};
          valid_q <= 1'b1;
          sig_q   <= (wid_q == FSW_TWO);
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign sig_o   = sig_q;

  // R8: strobe lasts a single cycle
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);
  // R8: capture counter stays inside the word
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FINAL);
  // R9: the signalling flag rises only together with a new byte
  p_sig_with_valid_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sig_q) |-> valid_q);
endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port #(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk,
  input  logic              fsx,
  input  logic              fsr,
  input  logic              dr,
  input  logic [WORD_W-1:0] tx_word,
  output logic              dx,
  output logic              dx_oe,
  output logic              mode_long,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              rx_sig
);
  localparam int N_IN = 4;
  localparam int I_BCLK = 0;
  localparam int I_FSX  = 1;
  localparam int I_FSR  = 2;
  localparam int I_DR   = 3;

  logic [N_IN-1:0] raw, lvl, prev, rise, fall;

  assign raw  = {dr, fsr, fsx, bclk};
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  pcm_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .lvl (lvl),
    .prev(prev)
  );

  pcm_tx_port #(.WORD_W(WORD_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .bclk_lvl (lvl[I_BCLK]),
    .bclk_rise(rise[I_BCLK]),
    .bclk_fall(fall[I_BCLK]),
    .fs_lvl   (lvl[I_FSX]),
    .fs_rise  (rise[I_FSX]),
    .fs_fall  (fall[I_FSX]),
    .word_i   (tx_word),
    .dx_o     (dx),
    .oe_o     (dx_oe),
    .long_o   (mode_long)
  );

  pcm_rx_port #(.WORD_W(WORD_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .bclk_rise(rise[I_BCLK]),
    .bclk_fall(fall[I_BCLK]),
    .fs_lvl   (lvl[I_FSR]),
    .fs_rise  (rise[I_FSR]),
    .dr_lvl   (lvl[I_DR]),
    .word_o   (rx_word),
    .valid_o  (rx_valid),
    .sig_o    (rx_sig)
  );

  // R1: nothing driven or strobed while in reset
  p_quiet_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!dx_oe && !rx_valid));
endmodule

// File: tb/sim_pcm_frame_port.sv
module sim_pcm_frame_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bclk = 1'b0, fsx = 1'b0, fsr = 1'b0, dr = 1'b0;
  logic [7:0] tx_word = 8'h00;
  logic       dx, dx_oe, mode_long, rx_valid, rx_sig;
  logic [7:0] rx_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  bit         mode_m = 0;
  logic [7:0] pend_m = 8'h00;
  int         rx_seen = 0;
  logic [7:0] rx_got;
  bit         sig_got;

  always #5 clk = ~clk;

  pcm_frame_port u0 (
    .clk(clk), .rst(rst), .bclk(bclk), .fsx(fsx), .fsr(fsr), .dr(dr),
    .tx_word(tx_word), .dx(dx), .dx_oe(dx_oe), .mode_long(mode_long),
    .rx_word(rx_word), .rx_valid(rx_valid), .rx_sig(rx_sig)
  );

  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      rx_seen++;
      rx_got  = rx_word;
      sig_got = rx_sig;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit sends(input bit m, input int lt);
    return m ? (lt >= 3) : (lt == 1);
  endfunction

  // One frame: fsx high across lt rising edges, fsr across lr rising edges
  task automatic frame(input int lt, input int lr, input logic [7:0] txb, input logic [7:0] rxb);
    bit         ok;
    int         s;
    logic [7:0] exp_b, got_b;
    int         rx_before;
    string      tag;
    ok    = sends(mode_m, lt);
    s     = mode_m ? 1 : 2;
    tag   = mode_m ? "R3" : "R4";
    exp_b = pend_m;
    pend_m = txb;
    got_b = 8'h00;
    rx_before = rx_seen;
    tx_word = txb;
    for (int p = 0; p < 12; p++) begin
      bclk = 1'b1;
      tick(3);
      if (p >= 1 && p <= 8) dr = rxb[8-p];
      tick(5);
      if (ok) begin
        chk(tag, dx_oe, (p >= s && p <= s + 7));
        if (p >= s && p <= s + 7) begin
          chk(tag, dx, exp_b[7-(p-s)]);
          got_b[7-(p-s)] = dx;
        end
      end
      tick(2);
      bclk = 1'b0;
      tick(3);
      if (p == 0) begin fsx = 1'b1; fsr = 1'b1; end
      if (p == lt) fsx = 1'b0;
      if (p == lr) fsr = 1'b0;
      tick(5);
      if (ok) begin
        if (p == s + 7) chk("R5", dx_oe, 0);
        else chk(tag, dx_oe, (p >= s && p < s + 7));
        if (p >= s && p < s + 7) chk("R10", dx, exp_b[7-(p-s)]);
      end else if (p >= lt) begin
        chk("R7", dx_oe, 0);
      end
      tick(2);
    end
    if (ok) chk("R6", got_b, exp_b);
    chk("R5", dx_oe, 0);
    if (lt == 1) mode_m = 0;
    else if (lt >= 3) mode_m = 1;
    chk("R2", mode_long, mode_m);
    chk("R8", rx_seen - rx_before, 1);
    chk("R8", rx_got, rxb);
    chk("R9", sig_got, (lr == 2));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C0D));
    tick(6);
    rst = 1'b0;
    tick(2);
    chk("R1", dx_oe, 0);
    chk("R1", rx_valid, 0);
    chk("R1", mode_long, 0);

    frame(3, 3, 8'hA5, 8'h3C);   // short held, long pulse: dropped, goes long (R7, R2)
    frame(3, 2, 8'h96, 8'hC3);   // long: sends A5 (R3, R6), signalling flag (R9)
    frame(2, 1, 8'h5A, 8'h81);   // long with two edges: aborted (R7)
    frame(1, 4, 8'hE7, 8'h7E);   // long with one edge: aborted, goes short (R7, R2)
    frame(1, 2, 8'h18, 8'h01);   // short: sends E7 (R4)
    frame(1, 5, 8'hFF, 8'h80);
    frame(4, 1, 8'h00, 8'hFE);   // back to long via drop
    frame(5, 6, 8'h42, 8'h55);

    for (int k = 0; k < 24; k++) begin
      int v;
      int lt;
      v  = $urandom_range(0, 5);
      lt = (v == 0) ? 1 : (v == 5 ? 2 : v + 2);
      frame(lt, $urandom_range(1, 6), 8'($urandom), 8'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule